// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands that share the 1/8/23 layout with an exponent bias of 127. It takes one operand pair on every clock cycle and returns one product per cycle after a fixed latency. A valid bit travels with each operation, so a gap in the input stream shows up as the same gap at the output.

The datapath has four register stages:

- **Unpack and partial products.** The first stage decodes both operands, forms the biased exponent sum minus one bias, and the XOR of the signs. It also splits the multiplier mantissa into groups and registers one partial product per group.
- **Accumulation.** The second stage adds the partial products into the double-length mantissa product. While it does so, the first stage is already producing the partial products of the next operation.
- **Normalize and round.** The third stage normalizes the product and rounds to nearest-even. A carry out of rounding renormalizes the mantissa and increments the exponent.
- **Final selection.** The last stage handles special values, exponent overflow and underflow, and packs the result into the output register.

Operands whose exponent field is zero are treated as zero. Subnormal results flush to signed zero.

Top module: `fpm_mul`

## Requirements
- R1: Word layout is sign in bit 31, biased exponent in bits 30:23, fraction in bits 22:0. For two normal operands with an in-range product, the result is the correctly rounded normalized product, e.g. 2.0 x 3.0 = 0x40C00000.
- R2: An operand pair accepted with in_valid high at a rising edge appears on result, with out_valid high, right after the fourth rising edge counted from that edge. A new pair is accepted every cycle, and idle input cycles give idle output cycles.
- R3: Except for NaN results, the result sign is the XOR of the operand signs.
- R4: Rounding is to nearest. An exact halfway case rounds to the value whose fraction LSB is 0.
- R5: When rounding carries out of the fraction, the fraction becomes zero and the exponent rises by one. For example, 0x3FFFF800 x 0x3F800400 = 0x40000000.
- R6: A biased result exponent of 255 or more gives infinity with the product sign, i.e. exponent field all ones and fraction zero.
- R7: A biased result exponent of 0 or below gives zero with the product sign. A product exactly at the smallest normal magnitude is kept.
- R8: An operand with exponent field 0, whatever its fraction, counts as zero. Zero times a finite value gives zero with the product sign.
- R9: Infinity times a finite nonzero value gives infinity with the product sign.
- R10: A NaN operand (exponent all ones, fraction nonzero), or infinity times zero, gives the quiet NaN 0x7FC00000.
- R11: While rst is high at a rising edge, out_valid and result are cleared to 0 by that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair on op_a/op_b is to be processed |
| op_a | input | 32 | Multiplicand, floating-point word |
| op_b | input | 32 | Multiplier, floating-point word |
| out_valid | output | 1 | result holds a finished product |
| result | output | 32 | Product, floating-point word |

## Verification
Every product is due exactly four rising edges after the edge that accepted its operands. Special values, overflow and underflow results take that same path, with no early exit. When the driver hands a pair to the design, it stamps the expected word with that due cycle. The monitor samples on the falling edge and compares both the value and the cycle, so a result that comes early, late, is missing or is unexpected is reported. Back-to-back operations and streams with gaps check that the partial-product and accumulation stages overlap without mixing operations.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  // Operand-pair class, decided in the first stage and carried to the last
  typedef enum logic [1:0] {
    CLS_NUM  = 2'd0,
    CLS_ZERO = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } cls_t;
endpackage

// File: rtl/fpm_ppgen.sv
module fpm_ppgen
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRP    = 6,
  localparam int DW     = 1 + EXP_W + FRAC_W,
  localparam int MANT_W = FRAC_W + 1,
  localparam int NPP    = (MANT_W + GRP - 1) / GRP,
  localparam int PPW    = MANT_W + GRP,
  localparam int EW     = EXP_W + 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [DW-1:0]                 op_a,
  input  logic [DW-1:0]                 op_b,
  output logic                          s1_valid,
  output logic                          s1_sign,
  output logic signed [EW-1:0]          s1_exp,
  output cls_t                          s1_cls,
  output logic [NPP-1:0][PPW-1:0]       s1_pp
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [EW-1:0] BIAS_S = EW'(BIAS);

  logic [EXP_W-1:0]   ea, eb;
  logic [FRAC_W-1:0]  fa, fb;
  logic [MANT_W-1:0]  ma;
  logic [NPP*GRP-1:0] mb_pad;
  logic nan_a, nan_b, inf_a, inf_b, zer_a, zer_b;
  cls_t cls_n;

  assign ea = op_a[FRAC_W +: EXP_W];
  assign eb = op_b[FRAC_W +: EXP_W];
  assign fa = op_a[FRAC_W-1:0];
  assign fb = op_b[FRAC_W-1:0];
  assign ma = {1'b1, fa};
  assign mb_pad = (NPP*GRP)'({1'b1, fb});

  always_comb begin
    nan_a = (&ea) && (|fa);
    nan_b = (&eb) && (|fb);
    inf_a = (&ea) && !(|fa);
    inf_b = (&eb) && !(|fb);
    zer_a = !(|ea);
    zer_b = !(|eb);
    if (nan_a || nan_b || (inf_a && zer_b) || (inf_b && zer_a))
      cls_n = CLS_NAN;
    else if (inf_a || inf_b)
      cls_n = CLS_INF;
    else if (zer_a || zer_b)
      cls_n = CLS_ZERO;
    else
      cls_n = CLS_NUM;
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
    s1_sign <= op_a[DW-1] ^ op_b[DW-1];
    s1_exp  <= $signed({2'b00, ea}) + $signed({2'b00, eb}) - BIAS_S;
    s1_cls  <= cls_n;
  end

  // One partial product per multiplier group, unshifted
  for (genvar j = 0; j < NPP; j++) begin : g_pp
    always_ff @(posedge clk) begin
      s1_pp[j] <= PPW'(ma) * PPW'(mb_pad[j*GRP +: GRP]);
    end
  end
endmodule

// File: rtl/fpm_accum.sv
module fpm_accum
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRP    = 6,
  localparam int MANT_W = FRAC_W + 1,
  localparam int NPP    = (MANT_W + GRP - 1) / GRP,
  localparam int PPW    = MANT_W + GRP,
  localparam int PW     = 2 * MANT_W,
  localparam int EW     = EXP_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    s1_valid,
  input  logic                    s1_sign,
  input  logic signed [EW-1:0]    s1_exp,
  input  cls_t                    s1_cls,
  input  logic [NPP-1:0][PPW-1:0] s1_pp,
  output logic                    s2_valid,
  output logic                    s2_sign,
  output logic signed [EW-1:0]    s2_exp,
  output cls_t                    s2_cls,
  output logic [PW-1:0]           s2_prod
);
  logic [PW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int j = 0; j < NPP; j++)
      acc = acc + (PW'(s1_pp[j]) << (j * GRP));
  end

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
    s2_sign <= s1_sign;
    s2_exp  <= s1_exp;
    s2_cls  <= s1_cls;
    s2_prod <= acc;
  end
endmodule

// File: rtl/fpm_round.sv
module fpm_round
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int MANT_W = FRAC_W + 1,
  localparam int PW     = 2 * MANT_W,
  localparam int EW     = EXP_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s2_valid,
  input  logic                 s2_sign,
  input  logic signed [EW-1:0] s2_exp,
  input  cls_t                 s2_cls,
  input  logic [PW-1:0]        s2_prod,
  output logic                 s3_valid,
  output logic                 s3_sign,
  output logic signed [EW-1:0] s3_exp,
  output cls_t                 s3_cls,
  output logic [FRAC_W-1:0]    s3_frac
);
  logic              hi;
  logic [PW-2:0]     sh;
  logic [FRAC_W-1:0] frac_t;
  logic              guard, sticky, rup;
  logic [FRAC_W:0]   frac_r;
  logic signed [EW-1:0] exp_n;

  always_comb begin
    hi     = s2_prod[PW-1];
    sh     = hi ? s2_prod[PW-2:0] : {s2_prod[PW-3:0], 1'b0};
    frac_t = sh[PW-2 -: FRAC_W];
    guard  = sh[FRAC_W];
    sticky = |sh[FRAC_W-1:0];
    rup    = guard && (sticky || frac_t[0]);
    frac_r = {1'b0, frac_t} + (FRAC_W+1)'(rup);
    exp_n  = s2_exp + EW'(hi) + EW'(frac_r[FRAC_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) s3_valid <= 1'b0;
    else     s3_valid <= s2_valid;
    s3_sign <= s2_sign;
    s3_cls  <= s2_cls;
    s3_exp  <= exp_n;
    s3_frac <= frac_r[FRAC_W-1:0];
  end
endmodule

// File: rtl/fpm_mul.sv
module fpm_mul
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRP    = 6,
  localparam int DW     = 1 + EXP_W + FRAC_W,
  localparam int MANT_W = FRAC_W + 1,
  localparam int NPP    = (MANT_W + GRP - 1) / GRP,
  localparam int PPW    = MANT_W + GRP,
  localparam int PW     = 2 * MANT_W,
  localparam int EW     = EXP_W + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic          out_valid,
  output logic [DW-1:0] result
);
  localparam logic signed [EW-1:0] EMAX = EW'((1 << EXP_W) - 1);
  localparam logic [DW-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic                    s1_valid, s1_sign;
  logic signed [EW-1:0]    s1_exp;
  cls_t                    s1_cls;
  logic [NPP-1:0][PPW-1:0] s1_pp;
  logic                    s2_valid, s2_sign;
  logic signed [EW-1:0]    s2_exp;
  cls_t                    s2_cls;
  logic [PW-1:0]           s2_prod;
  logic                    s3_valid, s3_sign;
  logic signed [EW-1:0]    s3_exp;
  cls_t                    s3_cls;
  logic [FRAC_W-1:0]       s3_frac;

  fpm_ppgen #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRP(GRP)) u_ppgen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .s1_valid(s1_valid), .s1_sign(s1_sign), .s1_exp(s1_exp),
    .s1_cls(s1_cls), .s1_pp(s1_pp)
  );

  fpm_accum #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRP(GRP)) u_accum (
    .clk(clk), .rst(rst),
    .s1_valid(s1_valid), .s1_sign(s1_sign), .s1_exp(s1_exp),
    .s1_cls(s1_cls), .s1_pp(s1_pp),
    .s2_valid(s2_valid), .s2_sign(s2_sign), .s2_exp(s2_exp),
    .s2_cls(s2_cls), .s2_prod(s2_prod)
  );

  fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .clk(clk), .rst(rst),
    .s2_valid(s2_valid), .s2_sign(s2_sign), .s2_exp(s2_exp),
    .s2_cls(s2_cls), .s2_prod(s2_prod),
    .s3_valid(s3_valid), .s3_sign(s3_sign), .s3_exp(s3_exp),
    .s3_cls(s3_cls), .s3_frac(s3_frac)
  );

  // Final stage: specials, range limits, packing
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= s3_valid;
      unique case (s3_cls)
        CLS_NAN:  result <= QNAN;
        CLS_INF:  result <= {s3_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        CLS_ZERO: result <= {s3_sign, {(DW-1){1'b0}}};
        default: begin
          if (s3_exp >= EMAX)
            result <= {s3_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          else if (s3_exp[EW-1] || (s3_exp == '0))
            result <= {s3_sign, {(DW-1){1'b0}}};
          else
            result <= {s3_sign, s3_exp[EXP_W-1:0], s3_frac};
        end
      endcase
    end
  end
endmodule

// File: rtl/fpm_mul_chk.sv
module fpm_mul_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int DW    = 1 + EXP_W + FRAC_W
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic          out_valid,
  input logic [DW-1:0] result
);
  localparam logic [DW-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [2:0] seen;
  always_ff @(posedge clk) begin
    if (rst)              seen <= '0;
    else if (seen != 3'd7) seen <= seen + 3'd1;
  end

  function automatic logic f_inf(input logic [DW-1:0] w);
    return (&w[FRAC_W +: EXP_W]) && !(|w[FRAC_W-1:0]);
  endfunction
  function automatic logic f_zero(input logic [DW-1:0] w);
    return !(|w[FRAC_W +: EXP_W]);
  endfunction
  function automatic logic f_fin_nz(input logic [DW-1:0] w);
    return !(&w[FRAC_W +: EXP_W]) && (|w[FRAC_W +: EXP_W]);
  endfunction

  logic res_nan;
  assign res_nan = (&result[FRAC_W +: EXP_W]) && (|result[FRAC_W-1:0]);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (seen >= 3'd4) |-> (out_valid == $past(in_valid, 4))); // R2
  AST_NAN_CANON: assert property (@(posedge clk) disable iff (rst)
    (out_valid && res_nan) |-> (result == QNAN)); // R10
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst)
    (seen >= 3'd4 && out_valid && !res_nan) |->
      (result[DW-1] == ($past(op_a[DW-1], 4) ^ $past(op_b[DW-1], 4)))); // R3
  AST_NO_SUBNORMAL_OUT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !(|result[FRAC_W +: EXP_W])) |-> !(|result[FRAC_W-1:0])); // R7
  AST_INF_PROPAGATE: assert property (@(posedge clk) disable iff (rst)
    (seen >= 3'd4 && out_valid && f_inf($past(op_a, 4)) && f_fin_nz($past(op_b, 4))) |->
      (result[DW-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})); // R9
  AST_ZERO_PROPAGATE: assert property (@(posedge clk) disable iff (rst)
    (seen >= 3'd4 && out_valid && f_zero($past(op_a, 4)) && !(&$past(op_b[DW-2 -: EXP_W], 4))) |->
      (result[DW-2:0] == '0)); // R8
endmodule

bind fpm_mul fpm_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fpm_mul_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .out_valid(out_valid), .result(result)
);

// File: tb/test_fpm_mul.sv
`timescale 1ns/1ps
module test_fpm_mul;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        out_valid;
  logic [31:0] result;

  fpm_mul i_fpm_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [31:0] exp;
    int          due;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic send(input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] e, input string req);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    op_a = a;
    op_b = b;
    it.exp = e;
    it.due = cyc + 4;
    it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = 32'hDEADBEEF;
      op_b = 32'h12345678;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R2 unexpected out_valid at cycle %0d: actual %h expected none", cyc, result);
        end else begin
          item_t it;
          it = q.pop_front();
          n_tests++;
          if (result !== it.exp || it.due != cyc) begin
            n_fail++;
            $display("FAIL %s: actual %h @%0d expected %h @%0d", it.req, result, cyc, it.exp, it.due);
          end
        end
      end else if (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        it = q.pop_front();
        n_tests++; n_fail++;
        $display("FAIL R2 missing result: actual none @%0d expected %h @%0d", cyc, it.exp, it.due);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R11: reset clears outputs
    in_valid = 1'b1;
    op_a = 32'h40000000;
    op_b = 32'h40400000;
    repeat (6) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || result !== 32'h0) begin
      n_fail++;
      $display("FAIL R11 reset: actual %b/%h expected 0/00000000", out_valid, result);
    end
    in_valid = 1'b0;
    rst = 1'b0;
    idle(2);

    // R1 normal products, back to back
    send(32'h40000000, 32'h40400000, 32'h40C00000, "R1 2*3");
    send(32'h3FC00000, 32'h3FC00000, 32'h40100000, "R1 1.5*1.5");
    send(32'hBFC00000, 32'h40200000, 32'hC0700000, "R3 -1.5*2.5");
    send(32'hBF800000, 32'hC0000000, 32'h40000000, "R3 -1*-2");
    // R4 round to nearest even
    send(32'h3F800001, 32'h3FC00000, 32'h3FC00002, "R4 tie up to even");
    send(32'h3F800003, 32'h3FC00000, 32'h3FC00004, "R4 tie down to even");
    send(32'h3FFFFFFF, 32'h3F800001, 32'h40000000, "R4 below half");
    // R5 rounding carry
    send(32'h3FFFF800, 32'h3F800400, 32'h40000000, "R5 round carry");
    idle(3);
    // R6 overflow
    send(32'h7F000000, 32'h7F000000, 32'h7F800000, "R6 overflow");
    send(32'hFF000000, 32'h7F000000, 32'hFF800000, "R6 neg overflow");
    send(32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, "R6 max finite kept");
    // R7 underflow
    send(32'h00800000, 32'h00800000, 32'h00000000, "R7 underflow");
    send(32'h80800000, 32'h3F000000, 32'h80000000, "R7 neg underflow");
    send(32'h00800000, 32'h3F800000, 32'h00800000, "R7 min normal kept");
    idle(1);
    // R8 zero and exponent-zero operands
    send(32'h00000001, 32'h3F800000, 32'h00000000, "R8 exp-zero operand");
    send(32'h80000000, 32'h40400000, 32'h80000000, "R8 signed zero");
    // R9 infinity
    send(32'h7F800000, 32'hC0000000, 32'hFF800000, "R9 inf*-2");
    send(32'h3F800000, 32'hFF800000, 32'hFF800000, "R9 1*-inf");
    // R10 NaN
    send(32'h7F800001, 32'h3F800000, 32'h7FC00000, "R10 nan in");
    send(32'h7F800000, 32'h00000000, 32'h7FC00000, "R10 inf*0");
    send(32'hFF800000, 32'h80000000, 32'h7FC00000, "R10 -inf*-0");
    send(32'h3F800000, 32'hFFC00123, 32'h7FC00000, "R10 neg nan in");
    // R2 stream with gaps
    for (int k = 0; k < 6; k++) begin
      send(32'h40000000, 32'h3F800000 + (k << 23), 32'h40000000 + (k << 23), "R2 stream");
      if (k % 2 == 1) idle(k);
    end
    idle(12);
    n_tests++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 leftover: actual %0d pending expected 0", q.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule